// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block produces the memory address for a single load or store, together with the value the base register should take afterwards. A base value is combined with an offset that is either a 12-bit unsigned immediate or a register value. The register offset can first pass through a shift or rotate. A direction bit chooses whether the offset is added to the base or subtracted from it.

Three indexing modes decide which value is used as the address and whether the base is rewritten. The address can be the sum with the base left alone, or the sum with the base also set to the sum. In the third mode the address is the unmodified base and the base is advanced to the sum afterwards. Addressing relative to the program counter uses the same path: the program counter is the base and the offset is an immediate.

The block also reports an alignment fault for half-word and word accesses. The work runs through two register stages. In the operand stage the offset is selected and shifted and the controls are captured. In the result stage the single adder runs, the address and base are chosen, and the alignment is checked. A new access may enter on every cycle.

Top module: `agu_addr_gen`

## Requirements
- R1: With `off_is_reg` = 0 the offset is `imm_off` zero-extended to 32 bits, and `shift_kind`/`shift_amt` have no effect. With `off_is_reg` = 1 the offset is `reg_off` after the shift.
- R2: With `add_off` = 1 the sum is base + offset, and with `add_off` = 0 it is base - offset. Both wrap modulo 2^32.
- R3: `addr_mode` = 2'b00 (pre-indexed): `eff_addr` = sum, `base_next` = base, `wb_en` = 0.
- R4: `addr_mode` = 2'b01 (pre-indexed with writeback): `eff_addr` = sum, `base_next` = sum, `wb_en` = 1. `wb_en` is never high without `out_valid`.
- R5: `addr_mode` = 2'b10 (post-indexed): `eff_addr` = base, `base_next` = sum, `wb_en` = 1.
- R6: `shift_kind` selects how `reg_off` is shifted by `shift_amt` (0 to 31): 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. An amount of 0 passes the value through unchanged for every kind.
- R7: `acc_size` gives the access width: 2'b00 byte, 2'b01 half-word, 2'b10 word. `align_fault` is set when a half-word address has bit 0 set, or when a word address has bit 1 or bit 0 set. A byte access never faults.
- R8: An access presented with `in_valid` high at a clock edge shows its results, with `out_valid` high for exactly one cycle, after the second following edge. Accesses on consecutive cycles produce results on consecutive cycles.
- R9: While `rst_n` is low, and right after it rises, `out_valid`, `wb_en`, `align_fault`, `eff_addr` and `base_next` are all 0. An access in flight when reset is asserted is discarded.
- R10: The reserved mode code 2'b11 behaves as pre-indexed without writeback, and size code 2'b11 is checked as a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An access is presented this cycle |
| base | input | 32 | Base register value (program counter for relative addressing) |
| off_is_reg | input | 1 | 1 selects the register offset, 0 selects the immediate |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Register offset before shifting |
| shift_kind | input | 2 | Shift or rotate applied to the register offset |
| shift_amt | input | 5 | Shift distance, 0 to 31 |
| add_off | input | 1 | 1 adds the offset, 0 subtracts it |
| addr_mode | input | 2 | Indexing mode |
| acc_size | input | 2 | Access width used for the alignment check |
| out_valid | output | 1 | Results below are valid this cycle |
| eff_addr | output | 32 | Effective memory address |
| base_next | output | 32 | Value for the base register after the access |
| wb_en | output | 1 | Base register should be written with `base_next` |
| align_fault | output | 1 | Address is misaligned for the access width |

## Verification
On every cycle the assertions check that results arrive two edges after each accepted access. They also check that the address equals the untouched base in post-indexed mode, that the pre-indexed mode leaves the base alone and raises no writeback, and that a writeback with pre-indexing returns the address itself. Two further properties cover byte accesses, which never fault, and the rule that a write strobe never appears without a valid result. The numeric results can only be shown by the bench's scenarios: the shift and rotate kinds, subtraction with wrap-around, the immediate path ignoring the shift controls, the reserved codes, the misaligned addresses, back-to-back streaming and a reset during an access.

// File: rtl/agu_pkg.sv
package agu_pkg;

    typedef enum logic [1:0] {
        AM_PRE    = 2'b00,
        AM_PRE_WB = 2'b01,
        AM_POST   = 2'b10,
        AM_RSVD   = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
    import agu_pkg::*;
#(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  value,
    input  shift_kind_e   kind,
    input  logic [SW-1:0] amt,
    output logic [W-1:0]  result
);
    logic [2*W-1:0] rot_wide;

    always_comb begin
        rot_wide = {value, value} >> amt;
        unique case (kind)
            SH_LSL: result = value << amt;
            SH_LSR: result = value >> amt;
            SH_ASR: result = W'($signed(value) >>> amt);
            SH_ROR: result = rot_wide[W-1:0];
        endcase
    end
endmodule

// File: rtl/agu_operand.sv
module agu_operand
    import agu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 12,
    parameter int SW    = $clog2(W)
) (
    input  logic             off_is_reg,
    input  logic [IMM_W-1:0] imm_off,
    input  logic [W-1:0]     reg_off,
    input  shift_kind_e      kind,
    input  logic [SW-1:0]    amt,
    output logic [W-1:0]     operand
);
    localparam int PAD_W = W - IMM_W;

    logic [W-1:0] shifted;

    agu_shifter #(.W(W), .SW(SW)) u_shifter (
        .value  (reg_off),
        .kind   (kind),
        .amt    (amt),
        .result (shifted)
    );

    // The immediate bypasses the shifter entirely.
    always_comb begin
        if (off_is_reg) operand = shifted;
        else            operand = {{PAD_W{1'b0}}, imm_off};
    end
endmodule

// File: rtl/agu_addsub.sv
module agu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         add,
    output logic [W-1:0] sum
);
    always_comb begin
        if (add) sum = a + b;
        else     sum = a - b;
    end
endmodule

// File: rtl/agu_align_chk.sv
module agu_align_chk
    import agu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] addr,
    input  acc_size_e    size,
    output logic         fault
);
    always_comb begin
        unique case (size)
            SZ_BYTE: fault = 1'b0;
            SZ_HALF: fault = addr[0];
            SZ_WORD,
            SZ_RSVD: fault = |addr[1:0];
        endcase
    end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
    import agu_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IMM_W   = 12,
    parameter int SHAMT_W = $clog2(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  base,
    input  logic               off_is_reg,
    input  logic [IMM_W-1:0]   imm_off,
    input  logic [ADDR_W-1:0]  reg_off,
    input  logic [1:0]         shift_kind,
    input  logic [SHAMT_W-1:0] shift_amt,
    input  logic               add_off,
    input  logic [1:0]         addr_mode,
    input  logic [1:0]         acc_size,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [ADDR_W-1:0]  base_next,
    output logic               wb_en,
    output logic               align_fault
);
    // ---------------- operand stage ----------------
    logic [ADDR_W-1:0] operand;

    agu_operand #(.W(ADDR_W), .IMM_W(IMM_W), .SW(SHAMT_W)) u_operand (
        .off_is_reg (off_is_reg),
        .imm_off    (imm_off),
        .reg_off    (reg_off),
        .kind       (shift_kind_e'(shift_kind)),
        .amt        (shift_amt),
        .operand    (operand)
    );

    logic              s1_valid;
    logic [ADDR_W-1:0] s1_base;
    logic [ADDR_W-1:0] s1_off;
    logic              s1_add;
    addr_mode_e        s1_mode;
    acc_size_e         s1_size;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_base  <= '0;
            s1_off   <= '0;
            s1_add   <= 1'b0;
            s1_mode  <= AM_PRE;
            s1_size  <= SZ_BYTE;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_base <= base;
                s1_off  <= operand;
                s1_add  <= add_off;
                s1_mode <= addr_mode_e'(addr_mode);
                s1_size <= acc_size_e'(acc_size);
            end
        end
    end

    // ---------------- result stage ----------------
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] addr_sel;
    logic [ADDR_W-1:0] base_sel;
    logic              wb_sel;
    logic              fault_sel;

    agu_addsub #(.W(ADDR_W)) u_addsub (
        .a   (s1_base),
        .b   (s1_off),
        .add (s1_add),
        .sum (sum)
    );

    always_comb begin
        unique case (s1_mode)
            AM_PRE_WB: begin
                addr_sel = sum;
                base_sel = sum;
                wb_sel   = 1'b1;
            end
            AM_POST: begin
                addr_sel = s1_base;
                base_sel = sum;
                wb_sel   = 1'b1;
            end
            AM_PRE,
            AM_RSVD: begin
                addr_sel = sum;
                base_sel = s1_base;
                wb_sel   = 1'b0;
            end
        endcase
    end

    agu_align_chk #(.W(ADDR_W)) u_align (
        .addr  (addr_sel),
        .size  (s1_size),
        .fault (fault_sel)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            eff_addr    <= '0;
            base_next   <= '0;
            wb_en       <= 1'b0;
            align_fault <= 1'b0;
        end else if (s1_valid) begin
            out_valid   <= 1'b1;
            eff_addr    <= addr_sel;
            base_next   <= base_sel;
            wb_en       <= wb_sel;
            align_fault <= fault_sel;
        end else begin
            out_valid   <= 1'b0;
            wb_en       <= 1'b0;
            align_fault <= 1'b0;
        end
    end

    // ---------------- assertions ----------------
    AST_WB_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> out_valid); // R4

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid); // R8

    AST_PRE_KEEPS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_mode == 2'b00) |-> ##2 (!wb_en && base_next == $past(base, 2))); // R3

    AST_PREWB_SAME_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_mode == 2'b01) |-> ##2 (wb_en && base_next == eff_addr)); // R4

    AST_POST_RAW_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_mode == 2'b10) |-> ##2 (wb_en && eff_addr == $past(base, 2))); // R5

    AST_BYTE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_size == 2'b00) |-> ##2 !align_fault); // R7

    AST_RSVD_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && addr_mode == 2'b11) |-> ##2 !wb_en); // R10
endmodule

// File: tb/agu_addr_gen_bench.sv
`timescale 1ns/1ps
module agu_addr_gen_bench;

    typedef struct packed {
        logic [31:0] base;
        logic        use_reg;
        logic [11:0] imm;
        logic [31:0] roff;
        logic [1:0]  sh;
        logic [4:0]  amt;
        logic        up;
        logic [1:0]  mode;
        logic [1:0]  size;
        logic [31:0] ea;
        logic [31:0] nb;
        logic        wb;
        logic        flt;
    } vec_t;

    localparam int NVEC = 16;
    // base, use_reg, imm, roff, sh, amt, up, mode, size, exp ea, exp base_next, exp wb, exp fault
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000_1000, 1'b0, 12'h010, 32'h0, 2'd0, 5'd0,  1'b1, 2'b00, 2'b10, 32'h0000_1010, 32'h0000_1000, 1'b0, 1'b0}, // R3 R1
        '{32'h0000_1000, 1'b0, 12'h004, 32'h0, 2'd0, 5'd0,  1'b0, 2'b01, 2'b10, 32'h0000_0FFC, 32'h0000_0FFC, 1'b1, 1'b0}, // R4 R2
        '{32'h0000_2000, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0,  1'b1, 2'b10, 2'b01, 32'h0000_2000, 32'h0000_2008, 1'b1, 1'b0}, // R5
        '{32'h0000_0100, 1'b1, 12'h000, 32'h3, 2'd0, 5'd4,  1'b1, 2'b00, 2'b10, 32'h0000_0130, 32'h0000_0100, 1'b0, 1'b0}, // R6 LSL
        '{32'h0000_1000, 1'b1, 12'h000, 32'h0000_1200, 2'd1, 5'd8, 1'b0, 2'b01, 2'b00, 32'h0000_0FEE, 32'h0000_0FEE, 1'b1, 1'b0}, // R6 LSR
        '{32'h1000_0000, 1'b1, 12'h000, 32'h8000_0000, 2'd2, 5'd4, 1'b1, 2'b00, 2'b10, 32'h0800_0000, 32'h1000_0000, 1'b0, 1'b0}, // R6 ASR
        '{32'h0000_0000, 1'b1, 12'h000, 32'h0000_00AB, 2'd3, 5'd8, 1'b1, 2'b10, 2'b00, 32'h0000_0000, 32'hAB00_0000, 1'b1, 1'b0}, // R6 ROR
        '{32'h0000_0010, 1'b1, 12'h000, 32'h0000_1234, 2'd1, 5'd0, 1'b1, 2'b00, 2'b01, 32'h0000_1244, 32'h0000_0010, 1'b0, 1'b0}, // R6 amt 0
        '{32'h0000_0100, 1'b0, 12'h001, 32'h0, 2'd0, 5'd0,  1'b1, 2'b00, 2'b01, 32'h0000_0101, 32'h0000_0100, 1'b0, 1'b1}, // R7 half odd
        '{32'h0000_0100, 1'b0, 12'h002, 32'h0, 2'd0, 5'd0,  1'b1, 2'b00, 2'b10, 32'h0000_0102, 32'h0000_0100, 1'b0, 1'b1}, // R7 word bit1
        '{32'h0000_0100, 1'b0, 12'h003, 32'h0, 2'd0, 5'd0,  1'b1, 2'b00, 2'b00, 32'h0000_0103, 32'h0000_0100, 1'b0, 1'b0}, // R7 byte
        '{32'h0000_0201, 1'b0, 12'h004, 32'h0, 2'd0, 5'd0,  1'b1, 2'b10, 2'b10, 32'h0000_0201, 32'h0000_0205, 1'b1, 1'b1}, // R7 R5 post fault
        '{32'h0000_0000, 1'b0, 12'hFFF, 32'hFFFF_FFFF, 2'd0, 5'd4, 1'b1, 2'b00, 2'b10, 32'h0000_0FFF, 32'h0000_0000, 1'b0, 1'b1}, // R1 shift ignored
        '{32'h0000_0040, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0,  1'b1, 2'b11, 2'b11, 32'h0000_0048, 32'h0000_0040, 1'b0, 1'b0}, // R10
        '{32'hFFFF_FFFC, 1'b0, 12'h008, 32'h0, 2'd0, 5'd0,  1'b1, 2'b01, 2'b10, 32'h0000_0004, 32'h0000_0004, 1'b1, 1'b0}, // R2 wrap up
        '{32'h0000_0000, 1'b0, 12'h004, 32'h0, 2'd0, 5'd0,  1'b0, 2'b00, 2'b10, 32'hFFFF_FFFC, 32'h0000_0000, 1'b0, 1'b0}  // R2 wrap down
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] base = '0;
    logic        off_is_reg = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic [1:0]  shift_kind = '0;
    logic [4:0]  shift_amt = '0;
    logic        add_off = 1'b0;
    logic [1:0]  addr_mode = '0;
    logic [1:0]  acc_size = '0;
    logic        out_valid;
    logic [31:0] eff_addr;
    logic [31:0] base_next;
    logic        wb_en;
    logic        align_fault;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    agu_addr_gen u_agu_addr_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .base        (base),
        .off_is_reg  (off_is_reg),
        .imm_off     (imm_off),
        .reg_off     (reg_off),
        .shift_kind  (shift_kind),
        .shift_amt   (shift_amt),
        .add_off     (add_off),
        .addr_mode   (addr_mode),
        .acc_size    (acc_size),
        .out_valid   (out_valid),
        .eff_addr    (eff_addr),
        .base_next   (base_next),
        .wb_en       (wb_en),
        .align_fault (align_fault)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        in_valid   = 1'b1;
        base       = v.base;
        off_is_reg = v.use_reg;
        imm_off    = v.imm;
        reg_off    = v.roff;
        shift_kind = v.sh;
        shift_amt  = v.amt;
        add_off    = v.up;
        addr_mode  = v.mode;
        acc_size   = v.size;
    endtask

    task automatic check_result(input string req, input vec_t v);
        chk(req, "out_valid",   32'(out_valid),   32'd1);
        chk(req, "eff_addr",    eff_addr,         v.ea);
        chk(req, "base_next",   base_next,        v.nb);
        chk(req, "wb_en",       32'(wb_en),       32'(v.wb));
        chk(req, "align_fault", 32'(align_fault), 32'(v.flt));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: outputs during reset
        repeat (3) @(negedge clk);
        chk("R9", "out_valid in reset", 32'(out_valid), 32'd0);
        chk("R9", "eff_addr in reset", eff_addr, 32'd0);
        chk("R9", "base_next in reset", base_next, 32'd0);
        chk("R9", "wb_en in reset", 32'(wb_en | align_fault), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", "out_valid after reset", 32'(out_valid), 32'd0);

        // Vector table, one access at a time
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            chk("R8", "out_valid early", 32'(out_valid), 32'd0);
            @(negedge clk);
            check_result($sformatf("vec%0d", i), VECS[i]);
            @(negedge clk);
            chk("R8", "out_valid one cycle", 32'(out_valid), 32'd0);
        end

        // R8: back-to-back accesses
        apply(VECS[3]);
        @(negedge clk);
        apply(VECS[6]);
        @(negedge clk);
        apply(VECS[14]);
        check_result("R8 stream first", VECS[3]);
        @(negedge clk);
        in_valid = 1'b0;
        check_result("R8 stream second", VECS[6]);
        @(negedge clk);
        check_result("R8 stream third", VECS[14]);
        @(negedge clk);
        chk("R8", "out_valid after stream", 32'(out_valid), 32'd0);
        chk("R4", "wb_en after stream", 32'(wb_en), 32'd0);

        // R9: reset during an access discards it
        apply(VECS[1]);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R9", "out_valid after mid reset", 32'(out_valid), 32'd0);
        chk("R9", "eff_addr after mid reset", eff_addr, 32'd0);
        @(negedge clk);
        chk("R9", "no stale result", 32'(out_valid | wb_en), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule